// File: doc/BRIEF.md
# Retrace Bias Calibration Sequencer

This block times one picture-tube bias calibration per vertical retrace interval. It takes a retrace level and a horizontal sync input, both already on the system clock, and detects their rising edges. It then counts sync pulses from the start of retrace. From that count it drives four control lines for an external analog sampling path. The first is a blanking strobe that forces the video drive to black. The second is a two-bit phase select: open, setup or sense. The last two are a grid pulse and a program pulse that starts high.

All windows are measured in sync pulses, not in clock time. The blanking window is 7 lines long. Inside it sit a 3-line setup phase and a 3-line sense phase. The counter restarts on each retrace rising edge and stops once the sequence is complete, so only one calibration runs per retrace. If retrace ends early, the outputs go idle at once and the counter is held at zero.

Top module: `retrace_bias_seq`

## Requirements
- R1: After retrace begins, sync pulses 1 to 13 change no output: autoBias=0, modeSel=2'b00 (open), gridPulse=0, progPulse=1.
- R2: The 14th sync pulse of a retrace sets autoBias to 1.
- R3: autoBias stays high for exactly 7 lines and falls on the 21st sync pulse.
- R4: modeSel encodes open=2'b00, setup=2'b01, sense=2'b10. The 15th sync pulse sets it to setup.
- R5: modeSel stays setup through pulses 15, 16 and 17. It is never non-open while autoBias is low.
- R6: The 18th sync pulse sets gridPulse=1 and progPulse=0 and switches modeSel to sense. This holds through pulse 20.
- R7: The 21st sync pulse returns gridPulse to 0, progPulse to 1 and modeSel to open.
- R8: Once pulse 21 has been reached, further sync pulses in the same retrace change nothing. The counter saturates.
- R9: A rising edge of vRetrace clears the count, so a new retrace runs a full new sequence from pulse 1.
- R10: When vRetrace falls, all outputs return to idle within 3 clock edges. Sync pulses while vRetrace is low are not counted.
- R11: Each sync pulse advances the count by exactly one, whatever its width in clocks. Each input passes a two-flop synchronizer, and the outputs change on the third rising clock edge after the input is first sampled high.
- R12: A synchronous active-low reset sets autoBias=0, gridPulse=0, progPulse=1 and modeSel=open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| vRetrace | input | 1 | Vertical retrace level, high during retrace |
| hSync | input | 1 | Horizontal sync pulse |
| autoBias | output | 1 | Blanking strobe, forces black level |
| modeSel | output | 2 | Phase select: 00 open, 01 setup, 10 sense |
| gridPulse | output | 1 | Grid pulse, high in the sense phase |
| progPulse | output | 1 | Program pulse, low in the sense phase |

## Verification
Several properties are checked on every clock:
- The grid and program pulses stay nested inside the sense phase.
- The phase select is never active outside the blanking strobe.
- Each detected sync pulse advances the counter by exactly one.
- The counter holds at its end value.
- A retrace drop clears the outputs on the next edge.

Other behaviour only the bench scenarios can show, because it depends on counting whole sequences of sync pulses. This covers:
- the exact pulse numbers where each window opens and closes;
- that pulse width has no effect on the count;
- a clean restart after an aborted retrace;
- the reset state in the middle of a sequence.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  typedef enum logic [1:0] {
    MODE_OPEN  = 2'b00,
    MODE_SETUP = 2'b01,
    MODE_SENSE = 2'b10
  } modeT;

  // strobes from the control to the output datapath
  typedef struct packed {
    logic forceIdle;  // retrace not active
    logic abOn;       // blanking window opens
    logic setupOn;    // setup phase opens
    logic senseOn;    // sense phase opens, grid/program pulses active
    logic endAll;     // sequence complete
  } strobeT;

endpackage

// File: rtl/rbs_edge.sv
module rbs_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic level,
  output logic rise
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-1:0], din};
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];

  // a detected rising edge lasts exactly one clock (R11)
  property pRiseSingle;
    @(posedge clk) disable iff (!rstN) rise |=> !rise;
  endproperty
  assert_rise_single_R11: assert property (pRiseSingle);

endmodule

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int IDLE_LINES  = 13,
  parameter int AB_LINES    = 7,
  parameter int SETUP_LINES = 3
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   vLevel,
  input  logic   vRise,
  input  logic   hRise,
  output strobeT strobe
);
  localparam int AB_START    = IDLE_LINES + 1;
  localparam int SETUP_START = AB_START + 1;
  localparam int SENSE_START = SETUP_START + SETUP_LINES;
  localparam int AB_END      = AB_START + AB_LINES;
  localparam int CW          = $clog2(AB_END + 1);

  localparam logic [CW-1:0] AB_START_C    = CW'(AB_START);
  localparam logic [CW-1:0] SETUP_START_C = CW'(SETUP_START);
  localparam logic [CW-1:0] SENSE_START_C = CW'(SENSE_START);
  localparam logic [CW-1:0] AB_END_C      = CW'(AB_END);

  logic [CW-1:0] cnt;
  logic [CW-1:0] nextCnt;
  logic          adv;

  assign adv     = vLevel && !vRise && hRise && (cnt != AB_END_C);
  assign nextCnt = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (!rstN)                cnt <= '0;
    else if (!vLevel || vRise) cnt <= '0;
    else if (adv)             cnt <= nextCnt;
  end

  always_comb begin
    strobe           = '0;
    strobe.forceIdle = !vLevel;
    strobe.abOn      = adv && (nextCnt == AB_START_C);
    strobe.setupOn   = adv && (nextCnt == SETUP_START_C);
    strobe.senseOn   = adv && (nextCnt == SENSE_START_C);
    strobe.endAll    = adv && (nextCnt == AB_END_C);
  end

  // R11: each accepted pulse advances the counter by exactly one
  property pOneStep;
    @(posedge clk) disable iff (!rstN)
      (vLevel && !vRise && hRise && cnt != AB_END_C) |=> (cnt == $past(cnt) + CW'(1));
  endproperty
  assert_one_step_R11: assert property (pOneStep);

  // R8: counter saturates at the end of the sequence
  property pSaturate;
    @(posedge clk) disable iff (!rstN)
      (vLevel && !vRise && cnt == AB_END_C) |=> (cnt == AB_END_C);
  endproperty
  assert_saturate_R8: assert property (pSaturate);

  // R10: counter held cleared outside retrace
  property pIdleClear;
    @(posedge clk) disable iff (!rstN) !vLevel |=> (cnt == '0);
  endproperty
  assert_idle_clear_R10: assert property (pIdleClear);

  // R9: retrace rising edge restarts the count
  property pRestart;
    @(posedge clk) disable iff (!rstN) vRise |=> (cnt == '0);
  endproperty
  assert_restart_R9: assert property (pRestart);

endmodule

// File: rtl/rbs_datapath.sv
module rbs_datapath
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  strobeT     strobe,
  output logic       autoBias,
  output logic [1:0] modeSel,
  output logic       gridPulse,
  output logic       progPulse
);
  modeT modeQ;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.forceIdle || strobe.endAll) begin
      autoBias  <= 1'b0;
      modeQ     <= MODE_OPEN;
      gridPulse <= 1'b0;
      progPulse <= 1'b1;
    end else begin
      if (strobe.abOn)    autoBias <= 1'b1;
      if (strobe.setupOn) modeQ    <= MODE_SETUP;
      if (strobe.senseOn) begin
        modeQ     <= MODE_SENSE;
        gridPulse <= 1'b1;
        progPulse <= 1'b0;
      end
    end
  end

  assign modeSel = modeQ;

  // R6: grid/program pulses only inside the sense phase of the blanking window
  property pGridNest;
    @(posedge clk) disable iff (!rstN)
      gridPulse |-> (modeQ == MODE_SENSE && !progPulse && autoBias);
  endproperty
  assert_grid_nest_R6: assert property (pGridNest);

  // R5: no calibration phase outside the blanking strobe
  property pModeInside;
    @(posedge clk) disable iff (!rstN) (modeQ != MODE_OPEN) |-> autoBias;
  endproperty
  assert_mode_inside_R5: assert property (pModeInside);

  // R10: retrace drop idles everything on the next edge
  property pIdleFollow;
    @(posedge clk) disable iff (!rstN)
      strobe.forceIdle |=> (!autoBias && modeQ == MODE_OPEN && !gridPulse && progPulse);
  endproperty
  assert_idle_follow_R10: assert property (pIdleFollow);

  // R7: end of sequence closes every window together
  property pEndClose;
    @(posedge clk) disable iff (!rstN)
      strobe.endAll |=> (!autoBias && modeQ == MODE_OPEN && !gridPulse && progPulse);
  endproperty
  assert_end_close_R7: assert property (pEndClose);

endmodule

// File: rtl/retrace_bias_seq.sv
module retrace_bias_seq
  import rbs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int IDLE_LINES  = 13,
  parameter int AB_LINES    = 7,
  parameter int SETUP_LINES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       vRetrace,
  input  logic       hSync,
  output logic       autoBias,
  output logic [1:0] modeSel,
  output logic       gridPulse,
  output logic       progPulse
);
  logic   vLevel, vRise, hLevel, hRise;
  strobeT strobe;

  rbs_edge #(.STAGES(SYNC_STAGES)) uVEdge (
    .clk(clk), .rstN(rstN), .din(vRetrace), .level(vLevel), .rise(vRise)
  );

  rbs_edge #(.STAGES(SYNC_STAGES)) uHEdge (
    .clk(clk), .rstN(rstN), .din(hSync), .level(hLevel), .rise(hRise)
  );

  rbs_ctrl #(
    .IDLE_LINES(IDLE_LINES), .AB_LINES(AB_LINES), .SETUP_LINES(SETUP_LINES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .vLevel(vLevel), .vRise(vRise), .hRise(hRise),
    .strobe(strobe)
  );

  rbs_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .autoBias(autoBias), .modeSel(modeSel),
    .gridPulse(gridPulse), .progPulse(progPulse)
  );

  // synchronized sync level is only used for its edge
  logic unusedH;
  assign unusedH = hLevel;

endmodule

// File: tb/sim_retrace_bias_seq.sv
module sim_retrace_bias_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic vRetrace = 1'b0;
  logic hSync = 1'b0;
  logic autoBias, gridPulse, progPulse;
  logic [1:0] modeSel;

  always #(CLK_PERIOD/2) clk = ~clk;

  retrace_bias_seq u0 (
    .clk(clk), .rstN(rstN), .vRetrace(vRetrace), .hSync(hSync),
    .autoBias(autoBias), .modeSel(modeSel),
    .gridPulse(gridPulse), .progPulse(progPulse)
  );

  typedef struct {
    logic       ab;
    logic [1:0] mode;
    logic       grid;
    logic       prog;
    string      req;
  } expT;

  expT expQ[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // expected outputs after sync pulse number n of a retrace
  function automatic expT expAfter(int n, string req);
    expT e;
    e.ab   = (n >= 14 && n < 21);
    e.mode = (n >= 15 && n <= 17) ? 2'b01 : (n >= 18 && n <= 20) ? 2'b10 : 2'b00;
    e.grid = (n >= 18 && n <= 20);
    e.prog = !(n >= 18 && n <= 20);
    e.req  = req;
    return e;
  endfunction

  function automatic string tagOf(int n);
    if (n <= 13)      return (n == 5) ? "R11" : "R1";
    else if (n == 14) return "R2";
    else if (n == 15) return "R4";
    else if (n <= 17) return "R5";
    else if (n <= 20) return "R6";
    else if (n == 21) return "R3/R7";
    else              return "R8";
  endfunction

  task automatic pushExp(expT e);
    expQ.push_back(e);
  endtask

  task automatic syncPulse(int width);
    hSync = 1'b1;
    repeat (width) @(negedge clk);
    hSync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // monitor: compare queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expT e;
        e = expQ.pop_front();
        checks++;
        if (autoBias !== e.ab || modeSel !== e.mode ||
            gridPulse !== e.grid || progPulse !== e.prog) begin
          errors++;
          $display("FAIL %s: got ab=%b mode=%b grid=%b prog=%b, expected ab=%b mode=%b grid=%b prog=%b",
                   e.req, autoBias, modeSel, gridPulse, progPulse,
                   e.ab, e.mode, e.grid, e.prog);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    pushExp(expAfter(0, "R12"));
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // full sequence with varied pulse widths and saturation
    vRetrace = 1'b1;
    repeat (6) @(negedge clk);
    for (int n = 1; n <= 25; n++) begin
      syncPulse((n % 4) + 1);
      pushExp(expAfter(n, tagOf(n)));
    end

    // retrace ends, then an aborted sequence
    vRetrace = 1'b0;
    repeat (6) @(negedge clk);
    vRetrace = 1'b1;
    repeat (6) @(negedge clk);
    for (int n = 1; n <= 16; n++) syncPulse(2);
    pushExp(expAfter(16, "R5"));
    vRetrace = 1'b0;
    repeat (3) @(negedge clk);
    pushExp(expAfter(0, "R10"));
    // pulses outside retrace are ignored
    for (int n = 1; n <= 15; n++) syncPulse(1);
    pushExp(expAfter(0, "R10"));

    // R9: a new retrace restarts from pulse 1
    vRetrace = 1'b1;
    repeat (6) @(negedge clk);
    for (int n = 1; n <= 13; n++) syncPulse(3);
    pushExp(expAfter(13, "R9"));
    syncPulse(3);
    pushExp(expAfter(14, "R9"));
    for (int n = 15; n <= 18; n++) syncPulse(1);
    pushExp(expAfter(18, "R6"));

    // R12: reset in the middle of the sense phase
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    pushExp(expAfter(0, "R12"));
    @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule